// File: doc/BRIEF.md
# Serial Step-Attenuator Programming Master

This block sits on the host side of a serially programmed step attenuator. A client offers a 5-bit attenuation code over a valid/ready handshake. When the block accepts the code it forms a 6-bit word, a forced zero followed by the code. It drives that word out most significant bit first on a data line, qualified by a serial clock, and then raises a latch-enable strobe so that the attenuator applies the word.

Every interval on the serial pins is a rounded-up count of system-clock cycles, derived from the system clock frequency in MHz and nanosecond parameters. These intervals are the clock phase widths, the data setup and hold, the strobe setup and the strobe width. The block also enforces a minimum spacing between updates, 40 µs by default. This matches the attenuator's 25 kHz limit on how often its setting may change.

Top module: `atten_serial_master`

## Requirements
- R1: While reset is low and on the first cycle after it is released, ser_clk, ser_data and ser_le are 0 and code_ready is 1.
- R2: A code is accepted on a rising clock edge where code_valid and code_ready are both 1, and code_ready is 0 in the cycle that follows.
- R3: Each accepted code produces a word that the attenuator samples on ser_clk rising edges. The first bit is 0, then code[4] (8 dB), code[3] (4 dB), code[2] (2 dB), code[1] (1 dB) and code[0] (0.5 dB).
- R4: Each high phase and each low phase of ser_clk lasts at least 50 ns, so the serial clock never exceeds 10 MHz.
- R5: ser_data changes only while ser_clk is low. It is stable for at least 10 ns before each rising edge and does not change within 10 ns after a falling edge.
- R6: ser_le is low whenever ser_clk is high. It rises only after at least 10 ns have passed since the last falling edge of the word.
- R7: Each word ends with exactly one ser_le high pulse that lasts at least 30 ns and then returns low.
- R8: code_ready returns to 1 exactly UPDATE_NS (rounded up to whole cycles; 10000 cycles at 250 MHz) after the acceptance edge, or later if the word has not finished. Two acceptances are therefore never closer than 40 µs.
- R9: The latched word equals the code present at acceptance. Changes on code, and code_valid pulses while code_ready is 0, have no effect on the pins.
- R10: Exactly six ser_clk rising edges occur between the end of one latch pulse and the start of the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| code_valid | input | 1 | Client offers a code |
| code | input | CODE_W (5) | Attenuation code, bit 4 = 8 dB down to bit 0 = 0.5 dB |
| code_ready | output | 1 | Block can accept a code |
| ser_clk | output | 1 | Serial shift clock to the attenuator |
| ser_data | output | 1 | Serial data to the attenuator |
| ser_le | output | 1 | Latch-enable strobe to the attenuator |

## Verification
The bench models the attenuator's shift register and transparent latch from the pins. Monitors time every edge in nanoseconds, so a design that moved data on the falling edge, trimmed the setup before the first bit, or let the strobe overlap the last clock pulse would show a timing failure rather than just a wrong value. The code is changed right after acceptance, and valid is held high while the block is busy. A design that read the code late or accepted work early would latch the wrong word or produce an extra frame. The ready-low span after each acceptance is measured exactly, which exposes an off-by-one in the update-gap counter. A reset in the middle of a word checks that the pins return idle and that the next word still has exactly six bits.

// File: rtl/atten_pkg.sv
package atten_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_HOLD,
        ST_LESU,
        ST_LEHI
    } atten_state_e;

    typedef struct packed {
        atten_state_e st;
        logic         sclk;
        logic         le;
    } atten_ctl_t;

    localparam atten_ctl_t CTL_RST = '{st: ST_IDLE, sclk: 1'b0, le: 1'b0};

    // nanoseconds to whole cycles, rounded up, never below one cycle
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned mhz);
        int unsigned c;
        c = (ns * mhz + 999) / 1000;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned sub_floor1(input int unsigned a, input int unsigned b);
        return (a > b) ? (a - b) : 1;
    endfunction

endpackage

// File: rtl/atten_down_cnt.sv
module atten_down_cnt #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/atten_frame_shift.sv
module atten_frame_shift #(
    parameter int unsigned CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [CODE_W-1:0] code,
    output logic              sbit,
    output logic              last
);

    localparam int unsigned FRAME_W = CODE_W + 1;
    localparam int unsigned BC_W    = $clog2(FRAME_W);

    typedef struct packed {
        logic [FRAME_W-1:0] sr;
        logic [BC_W-1:0]    left;
    } shift_t;

    shift_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load) begin
            sh_d.sr   = {1'b0, code};          // forced zero start bit leads the word
            sh_d.left = BC_W'(FRAME_W - 1);
        end else if (shift) begin
            sh_d.sr   = {sh_q.sr[FRAME_W-2:0], 1'b0};
            sh_d.left = sh_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign sbit = sh_q.sr[FRAME_W-1];
    assign last = (sh_q.left == '0);

endmodule

// File: rtl/atten_serial_master.sv
module atten_serial_master
    import atten_pkg::*;
#(
    parameter int unsigned CLK_MHZ      = 250,
    parameter int unsigned CODE_W       = 5,
    parameter int unsigned SCLK_HALF_NS = 50,
    parameter int unsigned SETUP_NS     = 10,
    parameter int unsigned HOLD_NS      = 10,
    parameter int unsigned LE_SETUP_NS  = 10,
    parameter int unsigned LE_PULSE_NS  = 30,
    parameter int unsigned UPDATE_NS    = 40000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              code_valid,
    input  logic [CODE_W-1:0] code,
    output logic              code_ready,
    output logic              ser_clk,
    output logic              ser_data,
    output logic              ser_le
);

    localparam int unsigned FRAME_W    = CODE_W + 1;
    localparam int unsigned HALF_CYC   = ns_to_cyc(SCLK_HALF_NS, CLK_MHZ);
    localparam int unsigned SETUP_CYC  = ns_to_cyc(SETUP_NS, CLK_MHZ);
    localparam int unsigned HOLD_CYC   = ns_to_cyc(HOLD_NS, CLK_MHZ);
    localparam int unsigned LESU_CYC   = ns_to_cyc(LE_SETUP_NS, CLK_MHZ);
    localparam int unsigned LEPW_CYC   = ns_to_cyc(LE_PULSE_NS, CLK_MHZ);
    localparam int unsigned UPDATE_CYC = ns_to_cyc(UPDATE_NS, CLK_MHZ);

    // low phase is split: hold part (old bit) then setup part (new bit)
    localparam int unsigned LOW_PH   = umax(sub_floor1(HALF_CYC, HOLD_CYC), SETUP_CYC);
    localparam int unsigned LESU_PH  = sub_floor1(LESU_CYC, HOLD_CYC);
    localparam int unsigned PH_MAX   = umax(umax(umax(LOW_PH, HALF_CYC), umax(HOLD_CYC, LESU_PH)), LEPW_CYC);
    localparam int unsigned PH_W     = $clog2(PH_MAX + 1);
    localparam int unsigned GAP_W    = $clog2(UPDATE_CYC + 1);

    localparam logic [PH_W-1:0]  LD_LOW  = PH_W'(LOW_PH - 1);
    localparam logic [PH_W-1:0]  LD_HIGH = PH_W'(HALF_CYC - 1);
    localparam logic [PH_W-1:0]  LD_HOLD = PH_W'(HOLD_CYC - 1);
    localparam logic [PH_W-1:0]  LD_LESU = PH_W'(LESU_PH - 1);
    localparam logic [PH_W-1:0]  LD_LEHI = PH_W'(LEPW_CYC - 1);
    localparam logic [GAP_W-1:0] LD_GAP  = GAP_W'(UPDATE_CYC - 1);

    atten_ctl_t      ctl_d, ctl_q;
    logic            ph_load;
    logic [PH_W-1:0] ph_val;
    logic            ph_zero;
    logic            gap_zero;
    logic            sh_load;
    logic            sh_shift;
    logic            sh_last;
    logic            accept;

    assign code_ready = (ctl_q.st == ST_IDLE) && gap_zero;
    assign accept     = code_valid && code_ready;

    atten_down_cnt #(.W(PH_W)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ph_load),
        .load_val (ph_val),
        .zero     (ph_zero)
    );

    atten_down_cnt #(.W(GAP_W)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (LD_GAP),
        .zero     (gap_zero)
    );

    atten_frame_shift #(.CODE_W(CODE_W)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (sh_load),
        .shift (sh_shift),
        .code  (code),
        .sbit  (ser_data),
        .last  (sh_last)
    );

    always_comb begin
        ctl_d    = ctl_q;
        ph_load  = 1'b0;
        ph_val   = '0;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (accept) begin
                    ctl_d.st = ST_LOW;
                    ph_load  = 1'b1;
                    ph_val   = LD_LOW;
                    sh_load  = 1'b1;
                end
            end
            ST_LOW: begin
                if (ph_zero) begin
                    ctl_d.st   = ST_HIGH;
                    ctl_d.sclk = 1'b1;
                    ph_load    = 1'b1;
                    ph_val     = LD_HIGH;
                end
            end
            ST_HIGH: begin
                if (ph_zero) begin
                    ctl_d.st   = ST_HOLD;
                    ctl_d.sclk = 1'b0;
                    ph_load    = 1'b1;
                    ph_val     = LD_HOLD;
                end
            end
            ST_HOLD: begin
                if (ph_zero) begin
                    ph_load = 1'b1;
                    if (sh_last) begin
                        ctl_d.st = ST_LESU;
                        ph_val   = LD_LESU;
                    end else begin
                        ctl_d.st = ST_LOW;
                        ph_val   = LD_LOW;
                        sh_shift = 1'b1;
                    end
                end
            end
            ST_LESU: begin
                if (ph_zero) begin
                    ctl_d.st = ST_LEHI;
                    ctl_d.le = 1'b1;
                    ph_load  = 1'b1;
                    ph_val   = LD_LEHI;
                end
            end
            ST_LEHI: begin
                if (ph_zero) begin
                    ctl_d.st = ST_IDLE;
                    ctl_d.le = 1'b0;
                end
            end
            default: ctl_d = CTL_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= CTL_RST;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ser_clk = ctl_q.sclk;
    assign ser_le  = ctl_q.le;

endmodule

// File: rtl/atten_serial_master_chk.sv
module atten_serial_master_chk #(
    parameter int unsigned FRAME_W    = 6,
    parameter int unsigned HALF_CYC   = 13,
    parameter int unsigned SETUP_CYC  = 3,
    parameter int unsigned HOLD_CYC   = 3,
    parameter int unsigned LESU_CYC   = 3,
    parameter int unsigned LEPW_CYC   = 8,
    parameter int unsigned UPDATE_CYC = 10000
) (
    input logic clk,
    input logic rst_n,
    input logic code_valid,
    input logic code_ready,
    input logic ser_clk,
    input logic ser_data,
    input logic ser_le
);

    localparam int unsigned SAT = 32'h7FFF_FFFF;

    int unsigned hi_run, lo_run, stab_run, le_run, since_acc, rises;
    logic        data_prev, le_prev, seen_acc;
    logic        acc;

    assign acc = code_valid && code_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run    <= 0;
            lo_run    <= SAT;
            stab_run  <= SAT;
            le_run    <= 0;
            since_acc <= 0;
            rises     <= 0;
            data_prev <= 1'b0;
            le_prev   <= 1'b0;
            seen_acc  <= 1'b0;
        end else begin
            hi_run    <= ser_clk ? ((hi_run < SAT) ? hi_run + 1 : SAT) : 0;
            lo_run    <= !ser_clk ? ((lo_run < SAT) ? lo_run + 1 : SAT) : 0;
            stab_run  <= (ser_data != data_prev) ? 1 : ((stab_run < SAT) ? stab_run + 1 : SAT);
            le_run    <= ser_le ? ((le_run < SAT) ? le_run + 1 : SAT) : 0;
            since_acc <= acc ? 1 : ((since_acc < SAT) ? since_acc + 1 : SAT);
            data_prev <= ser_data;
            le_prev   <= ser_le;
            if (acc) seen_acc <= 1'b1;
            if (le_prev && !ser_le) rises <= 0;
            else if ($rose(ser_clk)) rises <= rises + 1;
        end
    end

    AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> !code_ready); // R2

    AST_SCLK_HIGH_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_clk) |-> hi_run >= HALF_CYC); // R4

    AST_SCLK_LOW_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_clk) |-> lo_run >= HALF_CYC); // R4

    AST_DATA_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_clk) |-> stab_run >= SETUP_CYC); // R5

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ser_data) |-> (!ser_clk && lo_run >= HOLD_CYC)); // R5

    AST_LE_EXCLUDES_SCLK: assert property (@(posedge clk) disable iff (!rst_n)
        ser_le |-> !ser_clk); // R6

    AST_LE_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_le) |-> lo_run >= LESU_CYC); // R6

    AST_LE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_le) |-> le_run >= LEPW_CYC); // R7

    AST_UPDATE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        acc |-> (!seen_acc || since_acc >= UPDATE_CYC)); // R8

    AST_SIX_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_le) |-> rises == FRAME_W); // R10

endmodule

bind atten_serial_master atten_serial_master_chk #(
    .FRAME_W    (FRAME_W),
    .HALF_CYC   (HALF_CYC),
    .SETUP_CYC  (SETUP_CYC),
    .HOLD_CYC   (HOLD_CYC),
    .LESU_CYC   (LESU_CYC),
    .LEPW_CYC   (LEPW_CYC),
    .UPDATE_CYC (UPDATE_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .code_valid (code_valid),
    .code_ready (code_ready),
    .ser_clk    (ser_clk),
    .ser_data   (ser_data),
    .ser_le     (ser_le)
);

// File: tb/atten_serial_master_tb.sv
module atten_serial_master_tb;

    localparam longint CLK_NS      = 4;
    localparam longint HALF_MIN_NS = 50;
    localparam longint SU_MIN_NS   = 10;
    localparam longint HD_MIN_NS   = 10;
    localparam longint LESU_MIN_NS = 10;
    localparam longint LEPW_MIN_NS = 30;
    localparam longint GAP_NS      = 40000;
    localparam int     READY_LOW_N = int'(GAP_NS / CLK_NS) - 1;

    // {code[4:0], expected word[5:0]}
    localparam logic [10:0] VECS [0:7] = '{
        {5'h00, 6'b000000},
        {5'h1F, 6'b011111},
        {5'h01, 6'b000001},
        {5'h02, 6'b000010},
        {5'h04, 6'b000100},
        {5'h08, 6'b001000},
        {5'h10, 6'b010000},
        {5'h15, 6'b010101}
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       code_valid;
    logic [4:0] code_in;
    logic       code_ready;
    logic       ser_clk, ser_data, ser_le;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;
    longint cyc  = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    atten_serial_master u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .code_valid (code_valid),
        .code       (code_in),
        .code_ready (code_ready),
        .ser_clk    (ser_clk),
        .ser_data   (ser_data),
        .ser_le     (ser_le)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // attenuator model and pin timing monitors
    logic [5:0] sr_model, latch_model;
    int         rises, frames_done;
    longint     t_rise, t_fall, t_dchg, t_le_rise, t_acc;
    bit         acc_seen;
    logic       p_sclk, p_data, p_le;

    initial begin
        sr_model = '0; latch_model = '0; rises = 0; frames_done = 0;
        t_rise = -1000000; t_fall = -1000000; t_dchg = -1000000; t_le_rise = 0;
        t_acc = 0; acc_seen = 1'b0; p_sclk = 1'b0; p_data = 1'b0; p_le = 1'b0;
    end

    always @(negedge clk) begin
        longint now;
        now = cyc * CLK_NS;
        if (!rst_n) begin
            sr_model = '0; rises = 0;
            t_rise = -1000000; t_fall = -1000000; t_dchg = -1000000;
            acc_seen = 1'b0;
            p_sclk = ser_clk; p_data = ser_data; p_le = ser_le;
        end else begin
            if (code_valid && code_ready) begin
                if (acc_seen) chk((now - t_acc) >= GAP_NS, "R8 update spacing", now - t_acc, GAP_NS);
                acc_seen = 1'b1;
                t_acc = now;
            end
            if (ser_data !== p_data) begin
                chk(!ser_clk && !p_sclk, "R5 data moves only with clock low", ser_clk, 0);
                chk((now - t_fall) >= HD_MIN_NS, "R5 hold after fall", now - t_fall, HD_MIN_NS);
                t_dchg = now;
            end
            if (ser_clk && !p_sclk) begin
                chk(!ser_le, "R6 latch low while shifting", ser_le, 0);
                chk((now - t_dchg) >= SU_MIN_NS, "R5 setup before rise", now - t_dchg, SU_MIN_NS);
                chk((now - t_fall) >= HALF_MIN_NS, "R4 low phase", now - t_fall, HALF_MIN_NS);
                chk((now - t_rise) >= 2 * HALF_MIN_NS, "R4 clock period", now - t_rise, 2 * HALF_MIN_NS);
                sr_model = {sr_model[4:0], ser_data};
                rises++;
                t_rise = now;
            end
            if (!ser_clk && p_sclk) begin
                chk((now - t_rise) >= HALF_MIN_NS, "R4 high phase", now - t_rise, HALF_MIN_NS);
                t_fall = now;
            end
            if (ser_le && !p_le) begin
                chk(rises == 6, "R10 rising edges per word", rises, 6);
                chk((now - t_fall) >= LESU_MIN_NS, "R6 latch setup", now - t_fall, LESU_MIN_NS);
                t_le_rise = now;
            end
            if (ser_le) latch_model = sr_model;
            if (!ser_le && p_le) begin
                chk((now - t_le_rise) >= LEPW_MIN_NS, "R7 latch pulse width", now - t_le_rise, LEPW_MIN_NS);
                frames_done++;
                rises = 0;
            end
            p_sclk = ser_clk; p_data = ser_data; p_le = ser_le;
        end
    end

    task automatic accept_code(input logic [4:0] c);
        while (!code_ready) @(negedge clk);
        code_valid = 1'b1;
        code_in    = c;
        @(negedge clk);
        code_valid = 1'b0;
        code_in    = ~c;        // R9: later changes must not reach the word
        chk(code_ready == 1'b0, "R2 ready drops after accept", code_ready, 0);
    endtask

    task automatic wait_ready(output int low_n);
        low_n = 0;
        while (!code_ready) begin
            low_n++;
            @(negedge clk);
        end
    endtask

    task automatic check_idle(input string req);
        chk(ser_clk == 1'b0, req, ser_clk, 0);
        chk(ser_data == 1'b0, req, ser_data, 0);
        chk(ser_le == 1'b0, req, ser_le, 0);
        chk(code_ready == 1'b1, req, code_ready, 1);
    endtask

    initial begin
        int span;
        int f0;
        rst_n      = 1'b0;
        code_valid = 1'b0;
        code_in    = '0;
        repeat (5) @(negedge clk);
        check_idle("R1 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 after release");

        for (int i = 0; i < 8; i++) begin
            f0 = frames_done;
            accept_code(VECS[i][10:6]);
            wait_ready(span);
            chk(span == READY_LOW_N, "R8 ready low span", span, READY_LOW_N);
            chk(latch_model == VECS[i][5:0], "R3 latched word", latch_model, VECS[i][5:0]);
            chk(frames_done == f0 + 1, "R7 one latch pulse per code", frames_done, f0 + 1);
        end

        // R9: valid pulses while busy are ignored
        f0 = frames_done;
        accept_code(5'h0A);
        repeat (300) begin
            code_valid = 1'b1;
            code_in    = 5'h1B;
            @(negedge clk);
        end
        code_valid = 1'b0;
        wait_ready(span);
        chk(frames_done == f0 + 1, "R9 busy valid ignored (frames)", frames_done, f0 + 1);
        chk(latch_model == 6'b001010, "R9 busy valid ignored (word)", latch_model, 6'b001010);

        // reset in the middle of a word
        accept_code(5'h1F);
        repeat (60) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_idle("R1 reset mid-word");
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 ready after mid-word reset");
        f0 = frames_done;
        accept_code(5'h0C);
        wait_ready(span);
        chk(span == READY_LOW_N, "R8 ready low span after reset", span, READY_LOW_N);
        chk(latch_model == 6'b001100, "R3 word after reset", latch_model, 6'b001100);
        chk(frames_done == f0 + 1, "R10 full word after reset", frames_done, f0 + 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 180000, 0);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
            $finish;
        end
    end

endmodule